// File: doc/BRIEF.md
# Instruction Tag Tracker

This block lets a debugger halt the processor on a chosen instruction fetched over the external bus. Two active-low tag pins are sampled on each falling edge of the external bus clock, which the block sees as a single-cycle strobe. A pin at logic 0 marks one byte of the word being fetched. The byte marks are stored beside each word in a short instruction queue and move with that word as the queue advances.

When a marked word reaches the queue head, the block emits a one-cycle debug-entry request. That instruction is not issued. The same edge disarms tagging. While tagging is armed, a busy output holds off the serial debug command decoder.

Tagging begins only after an arm command. It stops whenever debug mode is active. Marking the low byte needs the low-strobe-enable input, and marking the high byte is always possible.

Top module: `itag_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` and `dbg_req` are 0.
- R2: A cycle with `arm_cmd` high and `dbg_active` low sets `busy` from the next cycle. `busy` then stays high until a debug request or `dbg_active` clears it.
- R3: `dbg_active` clears `busy` on the next edge and wins over `arm_cmd`. An entry already marked at the head then produces no request.
- R4: Pins are sampled in cycles where `eclk_fall` is high, and 0 on a pin means "mark". `tag_hi_n` marks the high byte, reported as bit 1 of `dbg_tag`. `tag_lo_n` marks the low byte, reported as bit 0. The two pins are decoded independently: 11 = none, 10 = low byte, 01 = high byte, 00 = both, written as {hi_n, lo_n}.
- R5: A low-byte mark is kept only if `lstrb_en` is 1 in the sampling cycle. A high-byte mark is kept regardless of `lstrb_en`.
- R6: While disarmed, the pins are ignored and fetched words carry no marks. No request is raised.
- R7: A marked word fetched into queue slot k (slot 0 is the head) reaches the head after k advances. `dbg_req` is high in the cycle after the marked word is at the head, and in no earlier cycle.
- R8: `dbg_req` lasts exactly one cycle, and `dbg_tag` carries the byte marks during that cycle. `busy` is 0 in that same cycle. The head's marks are cleared, so re-arming does not repeat the request.
- R9: `flush` empties the queue, drops all marks, and discards a sample not yet attached. It wins over a fetch in the same cycle.
- R10: A fetch into a full queue without an advance in the same cycle is discarded.
- R11: A sample attaches to the next fetch only, and a later strobe overwrites it. A fetch in a strobe cycle takes that cycle's sample, and the sample is used up by the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eclk_fall | input | 1 | One-cycle strobe at each external clock falling edge |
| tag_hi_n | input | 1 | High-byte tag pin, active low |
| tag_lo_n | input | 1 | Low-byte tag pin, active low |
| lstrb_en | input | 1 | Low strobe enabled; permits low-byte tags |
| fetch | input | 1 | Load a fetched word into the queue |
| advance | input | 1 | Remove the head entry and shift the queue |
| flush | input | 1 | Discard the queue contents and pending sample |
| arm_cmd | input | 1 | Arm tagging |
| dbg_active | input | 1 | Debug mode is active |
| dbg_req | output | 1 | One-cycle debug-entry request |
| dbg_tag | output | 2 | Byte marks of the requesting entry |
| busy | output | 1 | Tagging armed; serial commands blocked |

## Verification
The bench builds the block with its default queue depth of three entries. At that depth, filling the queue takes only three fetches, so a discarded fourth fetch is quick to reach. Likewise, a mark placed in the last slot needs just two advances to reach the head. A scoreboard expects every request in a specific cycle with specific byte marks. A request at any other time counts as a failure.

// File: rtl/itag_pkg.sv
// Shared definitions for the instruction tag tracker.
// Assumes a 16-bit bus word split into two bytes.
package itag_pkg;
    localparam int TAG_W   = 2;
    localparam int TAG_LO  = 0;
    localparam int TAG_HI  = 1;
    typedef logic [TAG_W-1:0] tag_t;
endpackage

// File: rtl/itag_capture.sv
// Samples the tag pins on external-clock falling-edge strobes and holds the
// sample until the next fetch. Assumes pins are already synchronised.
module itag_capture
    import itag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic eclk_fall,
    input  logic tag_hi_n,
    input  logic tag_lo_n,
    input  logic lstrb_en,
    input  logic fetch,
    input  logic flush,
    output tag_t fetch_tag
);
    tag_t sample;
    tag_t pend;

    // Decode the pins: each active-low pin marks its own byte.
    always_comb begin
        sample         = '0;
        sample[TAG_HI] = ~tag_hi_n;
        sample[TAG_LO] = ~tag_lo_n & lstrb_en;
    end

    // Tag presented with a fetch: a same-cycle sample wins over the held one.
    assign fetch_tag = armed ? (eclk_fall ? sample : pend) : '0;

    // Hold the latest sample until a fetch consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || fetch || !armed) begin
            pend <= '0;
        end else if (eclk_fall) begin
            pend <= sample;
        end
    end
endmodule

// File: rtl/itag_queue.sv
// Tag side of the instruction queue: a valid bit and byte marks per entry.
// Slot 0 is the head. Valid entries are contiguous from the head.
module itag_queue
    import itag_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch,
    input  tag_t fetch_tag,
    input  logic advance,
    input  logic flush,
    input  logic clr_head,
    output logic head_vld,
    output tag_t head_tag
);
    logic [DEPTH-1:0] vld;
    tag_t             tag [DEPTH];
    logic [DEPTH-1:0] sh_vld;
    tag_t             sh_tag [DEPTH];
    logic [DEPTH-1:0] wr_oh;

    // Apply a consumed-head clear and an optional shift toward the head.
    always_comb begin
        sh_vld = vld;
        for (int i = 0; i < DEPTH; i++) begin
            sh_tag[i] = tag[i];
        end
        if (clr_head) begin
            sh_tag[0] = '0;
        end
        if (advance) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                sh_vld[i] = vld[i + 1];
                sh_tag[i] = tag[i + 1];
            end
            sh_vld[DEPTH-1] = 1'b0;
            sh_tag[DEPTH-1] = '0;
        end
    end

    // The first free slot after the shift takes the fetched word.
    assign wr_oh = {DEPTH{fetch}} & ~sh_vld & {sh_vld[DEPTH-2:0], 1'b1};

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Per-entry state: flush clears, write loads, otherwise shift result.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                vld[g] <= 1'b0;
                tag[g] <= '0;
            end else if (wr_oh[g]) begin
                vld[g] <= 1'b1;
                tag[g] <= fetch_tag;
            end else begin
                vld[g] <= sh_vld[g];
                tag[g] <= sh_tag[g];
            end
        end
    end

    assign head_vld = vld[0];
    assign head_tag = tag[0];
endmodule

// File: rtl/itag_ctrl.sv
// Arm state and debug-entry request generation. Assumes the head
// view comes straight from queue registers.
module itag_ctrl
    import itag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_cmd,
    input  logic dbg_active,
    input  logic head_vld,
    input  tag_t head_tag,
    output logic armed,
    output logic clr_head,
    output logic dbg_req,
    output tag_t dbg_tag
);
    logic req_d;

    // A marked head while armed and outside debug mode triggers a request.
    assign req_d    = armed & ~dbg_active & head_vld & (|head_tag);
    assign clr_head = req_d;

    // Arm state: debug mode or a request disarms, with priority over arming.
    always_ff @(posedge clk) begin
        if (!rst_n || dbg_active || req_d) begin
            armed <= 1'b0;
        end else if (arm_cmd) begin
            armed <= 1'b1;
        end
    end

    // Registered one-cycle request with the marks of the entry that caused it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_req <= 1'b0;
            dbg_tag <= '0;
        end else begin
            dbg_req <= req_d;
            dbg_tag <= req_d ? head_tag : '0;
        end
    end
endmodule

// File: rtl/itag_tracker.sv
// Instruction tag tracker top. Captures tag pins, carries byte marks
// through the queue and requests debug entry at the head. The pipeline
// supplies fetch/advance/flush and must hold a requesting head.
module itag_tracker
    import itag_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eclk_fall,
    input  logic             tag_hi_n,
    input  logic             tag_lo_n,
    input  logic             lstrb_en,
    input  logic             fetch,
    input  logic             advance,
    input  logic             flush,
    input  logic             arm_cmd,
    input  logic             dbg_active,
    output logic             dbg_req,
    output logic [TAG_W-1:0] dbg_tag,
    output logic             busy
);
    logic armed;
    logic clr_head;
    logic head_vld;
    tag_t head_tag;
    tag_t fetch_tag;

    itag_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .eclk_fall (eclk_fall),
        .tag_hi_n  (tag_hi_n),
        .tag_lo_n  (tag_lo_n),
        .lstrb_en  (lstrb_en),
        .fetch     (fetch),
        .flush     (flush),
        .fetch_tag (fetch_tag)
    );

    itag_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch     (fetch),
        .fetch_tag (fetch_tag),
        .advance   (advance),
        .flush     (flush),
        .clr_head  (clr_head),
        .head_vld  (head_vld),
        .head_tag  (head_tag)
    );

    itag_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_cmd    (arm_cmd),
        .dbg_active (dbg_active),
        .head_vld   (head_vld),
        .head_tag   (head_tag),
        .armed      (armed),
        .clr_head   (clr_head),
        .dbg_req    (dbg_req),
        .dbg_tag    (dbg_tag)
    );

    assign busy = armed;
endmodule

// File: rtl/itag_tracker_chk.sv
// Port-level temporal checks for the tag tracker, bound to every instance.
module itag_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       arm_cmd,
    input logic       dbg_active,
    input logic       dbg_req,
    input logic [1:0] dbg_tag,
    input logic       busy
);
    assert_arm_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(arm_cmd) && !$past(dbg_active));

    assert_dbg_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active |=> !busy);

    assert_req_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> dbg_tag != 2'b00);

    assert_req_when_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> $past(busy));

    assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |=> !dbg_req);

    assert_req_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> !busy);
endmodule

bind itag_tracker itag_tracker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_cmd    (arm_cmd),
    .dbg_active (dbg_active),
    .dbg_req    (dbg_req),
    .dbg_tag    (dbg_tag),
    .busy       (busy)
);

// File: tb/itag_tracker_test.sv
module itag_tracker_test;
    logic clk = 1'b0;
    logic rst_n;
    logic eclk_fall, tag_hi_n, tag_lo_n, lstrb_en;
    logic fetch, advance, flush, arm_cmd, dbg_active;
    logic       dbg_req;
    logic [1:0] dbg_tag;
    logic       busy;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        int         at;
        logic [1:0] bytes;
        string      rq;
    } exp_t;
    exp_t expq[$];
    exp_t item;

    itag_tracker uut (
        .clk(clk), .rst_n(rst_n), .eclk_fall(eclk_fall), .tag_hi_n(tag_hi_n),
        .tag_lo_n(tag_lo_n), .lstrb_en(lstrb_en), .fetch(fetch),
        .advance(advance), .flush(flush), .arm_cmd(arm_cmd),
        .dbg_active(dbg_active), .dbg_req(dbg_req), .dbg_tag(dbg_tag),
        .busy(busy)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string rq, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", rq, got, exp, cyc);
        end
    endtask

    // Monitor: pops the scoreboard when a request is due, else expects none.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (expq.size() > 0 && expq[0].at == cyc) begin
                item = expq.pop_front();
                check(item.rq, {5'd0, dbg_req, dbg_tag}, {5'd0, 1'b1, item.bytes});
            end else begin
                check("R7 no request due", {7'd0, dbg_req}, 8'd0);
            end
        end
    end

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_req(input logic [1:0] bytes, input string rq);
        exp_t e;
        e.at = cyc + 1; e.bytes = bytes; e.rq = rq;
        expq.push_back(e);
    endtask

    task automatic fetch_w(input logic hn, input logic ln, input logic strobe);
        fetch = 1; eclk_fall = strobe; tag_hi_n = hn; tag_lo_n = ln;
        tick;
        fetch = 0; eclk_fall = 0; tag_hi_n = 1; tag_lo_n = 1;
    endtask

    task automatic strobe_only(input logic hn, input logic ln);
        eclk_fall = 1; tag_hi_n = hn; tag_lo_n = ln;
        tick;
        eclk_fall = 0; tag_hi_n = 1; tag_lo_n = 1;
    endtask

    task automatic adv;     advance = 1; tick; advance = 0; endtask
    task automatic do_flush; flush = 1; tick; flush = 0; endtask
    task automatic arm;     arm_cmd = 1; tick; arm_cmd = 0; endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run;
    end

    initial begin
        rst_n = 0; eclk_fall = 0; tag_hi_n = 1; tag_lo_n = 1; lstrb_en = 0;
        fetch = 0; advance = 0; flush = 0; arm_cmd = 0; dbg_active = 0;
        repeat (3) tick;
        check("R1 busy in reset", {7'd0, busy}, 0);
        check("R1 req in reset", {7'd0, dbg_req}, 0);
        rst_n = 1;
        tick;
        check("R1 busy after reset", {7'd0, busy}, 0);

        // R6: disarmed pins are ignored; word loads unmarked.
        lstrb_en = 1;
        fetch_w(0, 0, 1);
        tick;
        arm;
        check("R2 busy after arm", {7'd0, busy}, 1);
        repeat (3) tick;
        check("R2 busy holds", {7'd0, busy}, 1);
        do_flush;

        // R4: high-byte mark into the empty queue; R8 disarm on request.
        lstrb_en = 0;
        fetch_w(0, 1, 1);
        expect_req(2'b10, "R4 high byte");
        tick;
        check("R8 busy low with request", {7'd0, busy}, 0);
        arm;
        repeat (2) tick;   // head mark cleared: no repeat
        do_flush;

        // R5: low-byte mark needs lstrb_en; high byte does not.
        fetch_w(1, 0, 1);
        repeat (2) tick;
        do_flush;
        fetch_w(0, 0, 1);
        expect_req(2'b10, "R5 both pins without lstrb");
        tick; arm; do_flush;
        lstrb_en = 1;
        fetch_w(1, 0, 1);
        expect_req(2'b01, "R5 low byte");
        tick; arm; do_flush;
        fetch_w(0, 0, 1);
        expect_req(2'b11, "R4 both bytes");
        tick; arm; do_flush;

        // R7: mark travels from slot 2 to the head.
        fetch_w(1, 1, 1);
        fetch_w(1, 1, 0);
        fetch_w(0, 1, 1);
        adv;
        tick;
        adv;
        expect_req(2'b10, "R7 travel to head");
        tick; arm; do_flush;

        // R11: later strobe overwrites; held sample attaches to next fetch only.
        strobe_only(0, 1);
        strobe_only(1, 1);
        fetch_w(1, 1, 0);
        tick; do_flush;
        fetch_w(1, 1, 1);
        strobe_only(0, 1);
        tick;
        fetch_w(1, 1, 0);
        fetch_w(1, 1, 0);
        adv;
        expect_req(2'b10, "R11 held sample attaches");
        tick; arm;
        adv;
        tick; do_flush;

        // R9: flush drops queued marks and a pending sample.
        fetch_w(1, 1, 0);
        fetch_w(0, 1, 1);
        do_flush;
        fetch_w(1, 1, 0);
        fetch_w(1, 1, 0);
        adv;
        tick;
        do_flush;
        strobe_only(0, 1);
        do_flush;
        fetch_w(1, 1, 0);
        tick;
        check("R9 still armed", {7'd0, busy}, 1);
        do_flush;

        // R10: fetch into a full queue is discarded.
        fetch_w(1, 1, 0);
        fetch_w(1, 1, 0);
        fetch_w(1, 1, 0);
        fetch_w(0, 1, 1);
        adv; adv; adv;
        tick;
        do_flush;

        // R3: debug mode disarms and wins over arm; blocks a marked head.
        dbg_active = 1; tick; dbg_active = 0;
        check("R3 busy cleared", {7'd0, busy}, 0);
        arm_cmd = 1; dbg_active = 1; tick; arm_cmd = 0; dbg_active = 0;
        check("R3 priority over arm", {7'd0, busy}, 0);
        arm;
        dbg_active = 1;
        fetch_w(0, 1, 1);
        dbg_active = 0;
        repeat (3) tick;
        check("R3 no busy", {7'd0, busy}, 0);

        repeat (3) tick;
        check("R7 all requests seen", expq.size(), 0);
        finish_run;
    end
endmodule